// File: doc/BRIEF.md
# Shared-filter component slot sequencer

This block decides, clock by clock, which colour component (U, V or Y) is fed through one shared horizontal filter. It tags every filter slot with its component and marks the points where a downstream YUV-to-RGB converter or 4:2:2 packer has a finished pixel and a fresh chroma pair. Two orderings are offered. In full-chroma mode each output pixel is built from its own U, V and Y slots, so chroma is effectively upscaled by two and a pixel pair costs six slots. In fast mode chroma is filtered once per pixel pair and reused, so a pair costs four slots.

A line is started by a one-cycle `line_start` pulse. The block then issues a fixed number of pixel pairs and goes idle until the next pulse. The `stall` input freezes the sequence without losing its place. Two line counters are kept: one for luma lines and one for the chroma line to fetch. With 4:2:0 input, the chroma counter advances only after every second luma line, so each chroma line serves two output lines.

Top module: `chroma_slot_seq`

## Requirements
- R1: Each issued slot raises `slot_valid` for one cycle with `slot_tag` giving the component: U=0, V=1, Y=2. The code 3 never appears with `slot_valid`.
- R2: In full-chroma mode the slots run U,V,Y,U,V,Y per pixel pair, so one line of LINE_PAIRS pairs has 6*LINE_PAIRS slots.
- R3: In fast mode (`fast_seq`=1) the slots run U,V,Y,Y per pixel pair, so one line has 4*LINE_PAIRS slots.
- R4: `out_422`=1 selects fast ordering even when `fast_seq`=0.
- R5: `pix_valid` is high for exactly one cycle, in the cycle after each Y slot, and at no other time.
- R6: `chroma_upd` goes high together with `pix_valid` for every pixel in full-chroma mode, and only for the first pixel of each pair in fast mode.
- R7: A `line_start` pulse gives no slot in its own cycle. The first slot, a U, follows in the next cycle even if a line was running. The ordering mode (`fast_seq | out_422`) is sampled on that pulse.
- R8: While `stall`=1, no slot is issued. The sequence resumes at the component where it stopped.
- R9: After the last slot of the last pair, no further slot is issued until the next `line_start`.
- R10: `luma_line` increments by one (modulo 2^LINE_W) in the cycle in which a line's last slot appears. `frame_start` clears it to 0, and this takes priority.
- R11: `chroma_line` advances together with `luma_line` when `in_420`=0. When `in_420`=1 it advances only when the completing luma line number is odd. `frame_start` clears it to 0.
- R12: While `rst`=1 and after reset, all outputs are 0 and no slot is issued before a `line_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Clears both line counters |
| line_start | input | 1 | Begins a new line at component U |
| stall | input | 1 | Freezes slot issue |
| fast_seq | input | 1 | Selects U,V,Y,Y ordering |
| out_422 | input | 1 | 4:2:2 output requested; forces fast ordering |
| in_420 | input | 1 | 4:2:0 input; each chroma line is used twice |
| slot_valid | output | 1 | A filter slot is issued this cycle |
| slot_tag | output | 2 | Component of the slot (U=0, V=1, Y=2) |
| pix_valid | output | 1 | A pixel was completed by the preceding Y slot |
| chroma_upd | output | 1 | The converter should take a new U/V pair with this pixel |
| luma_line | output | LINE_W | Current luma line number |
| chroma_line | output | LINE_W | Chroma line to fetch |

## Verification
On every cycle, the assertions check the following. Tags stay legal. A pixel strobe always follows a Y slot. A chroma update never occurs without a pixel. A stall holds the slot position. A line start restarts the sequence. The counters step correctly. The full ordering patterns, the slot count per line in each mode, the forcing by `out_422`, the idle time after a line and the line-duplication pattern of the chroma counter are shown only by the bench. It compares every cycle against a model built from the requirements, under directed lines and random stalls, restarts and mode changes.

// File: rtl/slotseq_pkg.sv
package slotseq_pkg;
  typedef enum logic [1:0] {
    COMP_U = 2'd0,
    COMP_V = 2'd1,
    COMP_Y = 2'd2
  } comp_t;

  localparam logic [2:0] LAST_POS_FULL = 3'd5;
  localparam logic [2:0] LAST_POS_FAST = 3'd3;

  // Component carried by slot position pos within a pixel pair.
  function automatic comp_t comp_at(input logic fast, input logic [2:0] pos);
    comp_t c;
    if (fast) begin
      case (pos)
        3'd0:    c = COMP_U;
        3'd1:    c = COMP_V;
        default: c = COMP_Y;
      endcase
    end else begin
      case (pos)
        3'd0, 3'd3: c = COMP_U;
        3'd1, 3'd4: c = COMP_V;
        default:    c = COMP_Y;
      endcase
    end
    return c;
  endfunction

  // True for a Y slot whose pixel brings a freshly filtered chroma pair.
  function automatic logic fresh_chroma(input logic fast, input logic [2:0] pos);
    return (pos == 3'd2) || (!fast && pos == 3'd5);
  endfunction
endpackage

// File: rtl/slotseq_counter.sv
module slotseq_counter #(
  parameter int LINE_PAIRS = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       line_start,
  input  logic       stall,
  input  logic       fast_req,
  output logic       fast,
  output logic [2:0] pos,
  output logic       fire,
  output logic       line_done
);
  import slotseq_pkg::*;

  localparam int PAIR_W = (LINE_PAIRS > 1) ? $clog2(LINE_PAIRS) : 1;
  localparam logic [PAIR_W-1:0] LAST_PAIR = PAIR_W'(LINE_PAIRS - 1);

  logic              act_q;
  logic              fast_q;
  logic [2:0]        pos_q;
  logic [PAIR_W-1:0] pair_q;
  logic [2:0]        last_pos;
  logic              wrap;

  assign last_pos  = fast_q ? LAST_POS_FAST : LAST_POS_FULL;
  assign wrap      = (pos_q == last_pos);
  assign fire      = act_q & ~stall & ~line_start;
  assign line_done = fire & wrap & (pair_q == LAST_PAIR);
  assign fast      = fast_q;
  assign pos       = pos_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= 1'b0;
      fast_q <= 1'b0;
      pos_q  <= 3'd0;
      pair_q <= '0;
    end else if (line_start) begin
      act_q  <= 1'b1;
      fast_q <= fast_req;
      pos_q  <= 3'd0;
      pair_q <= '0;
    end else if (fire) begin
      if (line_done) begin
        act_q  <= 1'b0;
        pos_q  <= 3'd0;
        pair_q <= '0;
      end else if (wrap) begin
        pos_q  <= 3'd0;
        pair_q <= pair_q + 1'b1;
      end else begin
        pos_q  <= pos_q + 3'd1;
      end
    end
  end

  assert_restart_R7: assert property (@(posedge clk) disable iff (rst)
    line_start |=> (act_q && pos_q == 3'd0 && pair_q == '0));

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (stall && !line_start) |=> ($stable(pos_q) && $stable(pair_q) && $stable(act_q)));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!act_q && !line_start) |=> !act_q);

  assert_mode_latch_R7: assert property (@(posedge clk) disable iff (rst)
    !line_start |=> $stable(fast_q));
endmodule

// File: rtl/slotseq_decode.sv
module slotseq_decode (
  input  logic       clk,
  input  logic       rst,
  input  logic       fire,
  input  logic       fast,
  input  logic [2:0] pos,
  output logic       slot_valid,
  output logic [1:0] slot_tag,
  output logic       pix_valid,
  output logic       chroma_upd
);
  import slotseq_pkg::*;

  comp_t tag_q;
  logic  sv_q;
  logic  fresh_q;
  logic  pix_q;
  logic  upd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sv_q    <= 1'b0;
      tag_q   <= COMP_U;
      fresh_q <= 1'b0;
      pix_q   <= 1'b0;
      upd_q   <= 1'b0;
    end else begin
      sv_q    <= fire;
      tag_q   <= fire ? comp_at(fast, pos) : COMP_U;
      fresh_q <= fire & fresh_chroma(fast, pos);
      pix_q   <= sv_q & (tag_q == COMP_Y);
      upd_q   <= sv_q & (tag_q == COMP_Y) & fresh_q;
    end
  end

  assign slot_valid = sv_q;
  assign slot_tag   = tag_q;
  assign pix_valid  = pix_q;
  assign chroma_upd = upd_q;

  assert_tag_legal_R1: assert property (@(posedge clk) disable iff (rst)
    slot_valid |-> (slot_tag != 2'd3));

  assert_pix_after_y_R5: assert property (@(posedge clk) disable iff (rst)
    (slot_valid && slot_tag == COMP_Y) |=> pix_valid);

  assert_pix_source_R5: assert property (@(posedge clk) disable iff (rst)
    (!slot_valid || slot_tag != COMP_Y) |=> !pix_valid);

  assert_upd_with_pix_R6: assert property (@(posedge clk) disable iff (rst)
    chroma_upd |-> pix_valid);
endmodule

// File: rtl/slotseq_lines.sv
module slotseq_lines #(
  parameter int LINE_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_start,
  input  logic              line_done,
  input  logic              in_420,
  output logic [LINE_W-1:0] luma_line,
  output logic [LINE_W-1:0] chroma_line
);
  logic [LINE_W-1:0] luma_q;
  logic [LINE_W-1:0] chroma_q;
  logic              chroma_step;

  assign chroma_step = ~in_420 | luma_q[0];

  always_ff @(posedge clk) begin
    if (rst || frame_start) begin
      luma_q   <= '0;
      chroma_q <= '0;
    end else if (line_done) begin
      luma_q <= luma_q + 1'b1;
      if (chroma_step) chroma_q <= chroma_q + 1'b1;
    end
  end

  assign luma_line   = luma_q;
  assign chroma_line = chroma_q;

  assert_luma_step_R10: assert property (@(posedge clk) disable iff (rst)
    (!frame_start && line_done) |=> (luma_q == $past(luma_q) + 1'b1));

  assert_frame_clear_R10: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> (luma_q == '0 && chroma_q == '0));

  assert_chroma_reuse_R11: assert property (@(posedge clk) disable iff (rst)
    (!frame_start && line_done && in_420 && !luma_q[0]) |=> $stable(chroma_q));

  assert_chroma_follow_R11: assert property (@(posedge clk) disable iff (rst)
    (!frame_start && line_done && !in_420) |=> (chroma_q == $past(chroma_q) + 1'b1));
endmodule

// File: rtl/chroma_slot_seq.sv
module chroma_slot_seq #(
  parameter int LINE_PAIRS = 4,
  parameter int LINE_W     = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_start,
  input  logic              line_start,
  input  logic              stall,
  input  logic              fast_seq,
  input  logic              out_422,
  input  logic              in_420,
  output logic              slot_valid,
  output logic [1:0]        slot_tag,
  output logic              pix_valid,
  output logic              chroma_upd,
  output logic [LINE_W-1:0] luma_line,
  output logic [LINE_W-1:0] chroma_line
);
  logic       fast_req;
  logic       fast;
  logic [2:0] pos;
  logic       fire;
  logic       line_done;

  assign fast_req = fast_seq | out_422;

  slotseq_counter #(.LINE_PAIRS(LINE_PAIRS)) u_cnt (
    .clk(clk), .rst(rst), .line_start(line_start), .stall(stall),
    .fast_req(fast_req), .fast(fast), .pos(pos), .fire(fire),
    .line_done(line_done)
  );

  slotseq_decode u_dec (
    .clk(clk), .rst(rst), .fire(fire), .fast(fast), .pos(pos),
    .slot_valid(slot_valid), .slot_tag(slot_tag),
    .pix_valid(pix_valid), .chroma_upd(chroma_upd)
  );

  slotseq_lines #(.LINE_W(LINE_W)) u_lines (
    .clk(clk), .rst(rst), .frame_start(frame_start), .line_done(line_done),
    .in_420(in_420), .luma_line(luma_line), .chroma_line(chroma_line)
  );

  assert_force_fast_R4: assert property (@(posedge clk) disable iff (rst)
    (line_start && out_422) |=> fast);

  assert_no_slot_on_start_R7: assert property (@(posedge clk) disable iff (rst)
    line_start |=> !slot_valid);
endmodule

// File: tb/tb_chroma_slot_seq.sv
module tb_chroma_slot_seq;
  localparam int CLK_PERIOD = 10;
  localparam int PAIRS      = 4;
  localparam int LW         = 10;
  localparam int LMASK      = (1 << LW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_start = 1'b0, line_start = 1'b0, stall = 1'b0;
  logic fast_seq = 1'b0, out_422 = 1'b0, in_420 = 1'b0;
  logic slot_valid, pix_valid, chroma_upd;
  logic [1:0] slot_tag;
  logic [LW-1:0] luma_line, chroma_line;

  int total = 0, bad = 0;
  int m_act = 0, m_pos = 0, m_pair = 0, m_fast = 0;
  int p_sv = 0, p_tag = 0, p_fresh = 0;
  int m_luma = 0, m_chroma = 0;
  int slot_cnt = 0;
  int e_sv, e_tag, e_pix, e_cu;

  chroma_slot_seq #(.LINE_PAIRS(PAIRS), .LINE_W(LW)) dut (
    .clk(clk), .rst(rst), .frame_start(frame_start), .line_start(line_start),
    .stall(stall), .fast_seq(fast_seq), .out_422(out_422), .in_420(in_420),
    .slot_valid(slot_valid), .slot_tag(slot_tag), .pix_valid(pix_valid),
    .chroma_upd(chroma_upd), .luma_line(luma_line), .chroma_line(chroma_line)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int exp_tag(input int fast, input int pos);
    if (fast != 0) return (pos == 0) ? 0 : (pos == 1) ? 1 : 2;
    return pos % 3;
  endfunction

  function automatic int exp_fresh(input int fast, input int pos);
    return (pos == 2 || (fast == 0 && pos == 5)) ? 1 : 0;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One clock: drive at negedge, model the edge, compare at the next negedge.
  task automatic step(input bit ls, input bit st, input bit fs);
    int fire, last, done;
    line_start = ls; stall = st; frame_start = fs;
    fire = (m_act != 0 && !st && !ls) ? 1 : 0;
    last = (m_fast != 0) ? 3 : 5;
    done = (fire != 0 && m_pos == last && m_pair == PAIRS - 1) ? 1 : 0;
    e_sv  = fire;
    e_tag = exp_tag(m_fast, m_pos);
    e_pix = (p_sv != 0 && p_tag == 2) ? 1 : 0;
    e_cu  = (e_pix != 0 && p_fresh != 0) ? 1 : 0;
    p_sv = fire; p_tag = fire ? e_tag : 0;
    p_fresh = fire ? exp_fresh(m_fast, m_pos) : 0;
    if (fs) begin m_luma = 0; m_chroma = 0; end
    else if (done != 0) begin
      if (!in_420 || (m_luma % 2) == 1) m_chroma = (m_chroma + 1) & LMASK;
      m_luma = (m_luma + 1) & LMASK;
    end
    if (ls) begin
      m_act = 1; m_pos = 0; m_pair = 0; m_fast = (fast_seq | out_422) ? 1 : 0;
    end else if (fire != 0) begin
      if (done != 0) begin m_act = 0; m_pos = 0; m_pair = 0; end
      else if (m_pos == last) begin m_pos = 0; m_pair++; end
      else m_pos++;
    end
    @(posedge clk);
    @(negedge clk);
    if (fire != 0) slot_cnt++;
    check(slot_valid == e_sv[0], (st && !ls && m_act != 0) ? "R8 slot_valid" : "R9 slot_valid",
          int'(slot_valid), e_sv);
    if (e_sv != 0)
      check(int'(slot_tag) == e_tag, (p_fresh != 0 || m_fast == 0) ? "R2 slot_tag" : "R3 slot_tag",
            int'(slot_tag), e_tag);
    check(pix_valid == e_pix[0], "R5 pix_valid", int'(pix_valid), e_pix);
    check(chroma_upd == e_cu[0], "R6 chroma_upd", int'(chroma_upd), e_cu);
    check(int'(luma_line) == m_luma, "R10 luma_line", int'(luma_line), m_luma);
    check(int'(chroma_line) == m_chroma, "R11 chroma_line", int'(chroma_line), m_chroma);
    line_start = 1'b0; stall = 1'b0; frame_start = 1'b0;
  endtask

  task automatic run_line(output int n);
    slot_cnt = 0;
    step(1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 40; i++) step(1'b0, 1'b0, 1'b0);
    n = slot_cnt;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check(!slot_valid && !pix_valid && !chroma_upd && luma_line == 0 && chroma_line == 0,
          "R12 reset outputs", int'(slot_valid), 0);
    rst = 1'b0;
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 1'b0);
    check(slot_valid == 1'b0, "R12 idle after reset", int'(slot_valid), 0);

    // R2 / R9: full-chroma line
    run_line(n);
    check(n == 6 * PAIRS, "R2 R9 slots per full line", n, 6 * PAIRS);
    // R3: fast line
    fast_seq = 1'b1;
    run_line(n);
    check(n == 4 * PAIRS, "R3 slots per fast line", n, 4 * PAIRS);
    // R4: 4:2:2 output forces fast
    fast_seq = 1'b0; out_422 = 1'b1;
    run_line(n);
    check(n == 4 * PAIRS, "R4 out_422 forces fast", n, 4 * PAIRS);
    out_422 = 1'b0;

    // R7: restart in mid line, first slot is U
    step(1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b0);
    check(slot_valid == 1'b0, "R7 no slot on start", int'(slot_valid), 0);
    step(1'b0, 1'b0, 1'b0);
    check(slot_valid && slot_tag == 2'd0, "R7 restart at U", int'(slot_tag), 0);
    // R8: stall freezes, resumes with V
    step(1'b0, 1'b1, 1'b0);
    check(slot_valid == 1'b0, "R8 no slot in stall", int'(slot_valid), 0);
    step(1'b0, 1'b1, 1'b0);
    step(1'b0, 1'b0, 1'b0);
    check(slot_tag == 2'd1, "R8 resume at V", int'(slot_tag), 1);
    for (int i = 0; i < 30; i++) step(1'b0, 1'b0, 1'b0);

    // R11: 4:2:0 line duplication over four lines
    step(1'b0, 1'b0, 1'b1);
    in_420 = 1'b1;
    for (int l = 0; l < 4; l++) run_line(n);
    check(int'(chroma_line) == 2 && int'(luma_line) == 4, "R11 chroma reuse",
          int'(chroma_line), 2);
    in_420 = 1'b0;

    // Random mix
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(0, 99) < 3) fast_seq = $urandom_range(0, 1) != 0;
      if ($urandom_range(0, 99) < 3) out_422  = $urandom_range(0, 1) != 0;
      if ($urandom_range(0, 99) < 2) in_420   = $urandom_range(0, 1) != 0;
      step($urandom_range(0, 39) == 0, $urandom_range(0, 4) == 0, $urandom_range(0, 299) == 0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule